// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

This block is a synthesizable behavioural model of a small synchronous burst SRAM. The output path is registered. It is meant to stand in for an external cache-style memory in a simulation or an emulation build. Two address-status strobes start a burst. The processor strobe always starts a read and is gated by the main chip enable. The controller strobe starts either a read or a write, and the write inputs decide which. Once a burst is open, a cycle with both strobes inactive continues it. The advance input then either steps a two-bit burst counter or holds it. The counter rewrites only the two low address bits. A static order input selects linear (add) or interleaved (XOR) stepping.

Each word is made of byte lanes, and each lane carries a ninth bit. A global write stores every lane. Otherwise a gate input decides whether the per-lane selects are honoured. Read data passes through an address stage and then an output register, so an address sampled at one edge shows its data after the following edge. An output-enable input and a sleep input act combinationally on the drive flag. Sleep also freezes all state. The two buses are kept apart. When the drive flag is low, the output bus is forced to zero.

Top module: `burst_sram_model`

## Requirements
- R1: After reset, `rdrive` is 0 and `rdata` is 0 until a read has passed through the pipeline.
- R2: A cycle is a deselect in either of two cases: `chip_en_n`=1 with `strb_ctl_n`=0, or `chip_en_n`=0 with either strobe low while the chip is not selected. The chip is selected when `sel_a`=1 and `sel_b_n`=0. A deselect issues no access, and `rdrive` is 0 in the cycle after the next edge.
- R3: `strb_cpu_n` is ignored while `chip_en_n`=1. With the chip selected and `chip_en_n`=0, `strb_cpu_n`=0 loads `addr` and starts a read, whatever the write inputs are.
- R4: With the chip selected, `strb_cpu_n`=1 and `strb_ctl_n`=0, `addr` is loaded. The cycle writes if `wr_all_n`=0, or if `lane_gate_n`=0 and any `lane_n` bit is 0. Otherwise the cycle reads.
- R5: A cycle with `strb_ctl_n`=1 and either `strb_cpu_n`=1 or `chip_en_n`=1 continues the burst. `step_n`=0 advances the counter (modulo 4) before the access, and `step_n`=1 reuses the current address. The write inputs make the cycle a read or a write.
- R6: The two low address bits are the loaded low bits combined with the counter. When `burst_xor`=0 they are added modulo 4. When `burst_xor`=1 they are XORed. The upper bits stay as loaded.
- R7: Lane k is bits [9k+8:9k]. `wr_all_n`=0 writes every lane. With `wr_all_n`=1 and `lane_gate_n`=1, `lane_n` has no effect. With `lane_gate_n`=0, each lane whose `lane_n` bit is 0 is written, and several lanes may be written in one cycle.
- R8: For a read whose inputs are sampled at edge N, `rdata` holds the word after edge N+1, reading the array as it stood before edge N+1.
- R9: While `out_en_n`=1, `rdrive` is 0 and `rdata` is 0. Valid data held in the pipeline is not lost.
- R10: While the present inputs form a write cycle, `rdrive` is 0.
- R11: While `sleep_i`=1, no register or array location changes, `rdrive` is 0, and stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| burst_xor | input | 1 | Static burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| chip_en_n | input | 1 | Main chip enable, active low; gates the processor strobe |
| sel_a | input | 1 | Chip select, active high |
| sel_b_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_gate_n | input | 1 | Enables the per-lane selects, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep: freezes state and blocks drive |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driving |
| rdrive | output | 1 | Read data is valid and driven |

## Verification
The bench targets the places where a burst wraps, which differ between linear and interleaved stepping. A model that carries into address bit 2, or that uses the wrong order, returns neighbouring words. It also tries the processor strobe with every write input active. A design that let that strobe write would corrupt a stored word, and the next read of that word would show it. Partial lane writes under each gate setting are checked, since a wrong lane mapping merges bytes into the wrong positions. Deselect, output enable and sleep are placed in the middle of bursts. A design that kept driving, lost the pipeline, or advanced during sleep would show a wrong `rdrive` or wrong data on the following reads.

// File: rtl/burst_sram_model.sv
`timescale 1ns/1ps
module burst_sram_model #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    burst_xor,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    chip_en_n,
  input  logic                    sel_a,
  input  logic                    sel_b_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    lane_gate_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    out_en_n,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdrive
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [ADDR_W-1:0] base_q, base_d, acc_addr, stage_addr;
  logic [1:0]        cnt_q, cnt_d, low_bits;
  logic              stage_rd, out_vld;
  logic [DW-1:0]     out_q;

  wire selected  = !chip_en_n && sel_a && !sel_b_n;
  wire start_cpu = !chip_en_n && !strb_cpu_n && selected;
  wire start_ctl = selected && strb_cpu_n && !strb_ctl_n;
  wire carry_on  = strb_ctl_n && (strb_cpu_n || chip_en_n);
  wire wr_req    = !wr_all_n || (!lane_gate_n && !(&lane_n));
  wire ctl_side  = start_ctl || carry_on;
  wire is_write  = ctl_side && wr_req;
  wire is_read   = start_cpu || (ctl_side && !wr_req);
  wire [LANES-1:0] lane_we = !wr_all_n ? {LANES{1'b1}} : (!lane_gate_n ? ~lane_n : '0);

  always_comb begin
    base_d = (start_cpu || start_ctl) ? addr : base_q;
    if (start_cpu || start_ctl)     cnt_d = 2'd0;
    else if (carry_on && !step_n)   cnt_d = cnt_q + 2'd1;
    else                            cnt_d = cnt_q;
    low_bits = burst_xor ? (base_d[1:0] ^ cnt_d) : (base_d[1:0] + cnt_d);
    acc_addr = {base_d[ADDR_W-1:2], low_bits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      cnt_q      <= '0;
      stage_addr <= '0;
      stage_rd   <= 1'b0;
      out_vld    <= 1'b0;
      out_q      <= '0;
    end else if (!sleep_i) begin
      base_q     <= base_d;
      cnt_q      <= cnt_d;
      stage_addr <= acc_addr;
      stage_rd   <= is_read;
      out_vld    <= stage_rd;
      out_q      <= mem[stage_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !sleep_i && is_write) begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_we[k]) mem[acc_addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
      end
    end
  end

  assign rdrive = out_vld && !out_en_n && !sleep_i && !is_write;
  assign rdata  = rdrive ? out_q : '0;
endmodule

module burst_sram_model_chk #(
  parameter int DW = 36,
  parameter int LANES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en_n,
  input logic          sel_a,
  input logic          sel_b_n,
  input logic          strb_cpu_n,
  input logic          strb_ctl_n,
  input logic          wr_all_n,
  input logic          lane_gate_n,
  input logic [LANES-1:0] lane_n,
  input logic          out_en_n,
  input logic          sleep_i,
  input logic [DW-1:0] rdata,
  input logic          rdrive,
  input logic          stage_rd,
  input logic          out_vld,
  input logic [DW-1:0] out_q
);
  wire chosen = sel_a && !sel_b_n;
  wire desel  = (chip_en_n && !strb_ctl_n) ||
                (!chip_en_n && (!strb_cpu_n || !strb_ctl_n) && !chosen);
  wire wcyc   = ((!chip_en_n && chosen && strb_cpu_n && !strb_ctl_n) ||
                 (strb_ctl_n && (strb_cpu_n || chip_en_n))) &&
                (!wr_all_n || (!lane_gate_n && lane_n != '1));

  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (desel && !sleep_i) ##1 !sleep_i |=> !rdrive);
  a_r3_cpu_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en_n && chosen && !strb_cpu_n && !sleep_i) |=> stage_rd);
  a_r8_stage_to_output: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_rd && !sleep_i) |=> out_vld);
  a_r9_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!rdrive && rdata == '0));
  a_r10_write_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (wcyc && !sleep_i) |-> !rdrive);
  a_r11_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !rdrive);
  a_r11_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(out_q) && $stable(out_vld)));
endmodule

bind burst_sram_model burst_sram_model_chk #(.DW(LANES*LANE_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .sel_a(sel_a), .sel_b_n(sel_b_n),
  .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .wr_all_n(wr_all_n),
  .lane_gate_n(lane_gate_n), .lane_n(lane_n), .out_en_n(out_en_n), .sleep_i(sleep_i),
  .rdata(rdata), .rdrive(rdrive), .stage_rd(stage_rd), .out_vld(out_vld), .out_q(out_q)
);

// File: tb/burst_sram_model_tb.sv
`timescale 1ns/1ps
module burst_sram_model_tb_top;
  localparam int AW = 6, NL = 4, LW = 9, DW = NL*LW, DEP = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, burst_xor = 1'b0;
  logic [AW-1:0] addr = '0;
  logic chip_en_n = 1'b1, sel_a = 1'b1, sel_b_n = 1'b0;
  logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b0, step_n = 1'b1;
  logic wr_all_n = 1'b1, lane_gate_n = 1'b1;
  logic [NL-1:0] lane_n = '1;
  logic out_en_n = 1'b0, sleep_i = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdrive;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [DW-1:0] mm [DEP];
  bit [NL-1:0]   mk [DEP];
  logic [AW-1:0] m_base, m_a1;
  logic [1:0]    m_cnt;
  bit            m_rd1, m_vld;
  logic [DW-1:0] m_q;
  bit [NL-1:0]   m_qk;

  burst_sram_model #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_xor(burst_xor), .addr(addr), .chip_en_n(chip_en_n),
    .sel_a(sel_a), .sel_b_n(sel_b_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .step_n(step_n), .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n), .lane_n(lane_n),
    .out_en_n(out_en_n), .sleep_i(sleep_i), .wdata(wdata), .rdata(rdata), .rdrive(rdrive));

  always #2.5 clk = ~clk;

  function automatic bit fx_sel();
    return !chip_en_n && sel_a && !sel_b_n;
  endfunction
  function automatic bit fx_wreq();
    return !wr_all_n || (!lane_gate_n && lane_n != '1);
  endfunction
  function automatic bit fx_ctlside();
    return (fx_sel() && strb_cpu_n && !strb_ctl_n) || (strb_ctl_n && (strb_cpu_n || chip_en_n));
  endfunction
  function automatic bit fx_wcyc();
    return fx_ctlside() && fx_wreq();
  endfunction

  task automatic model_reset();
    m_base = '0; m_a1 = '0; m_cnt = '0; m_rd1 = 0; m_vld = 0; m_q = '0; m_qk = '0;
  endtask

  task automatic model_edge();
    bit start;
    bit cont;
    logic [1:0] lo;
    logic [AW-1:0] eff;
    if (sleep_i) return;
    m_vld = m_rd1;
    m_q   = mm[m_a1];
    m_qk  = mk[m_a1];
    start = (fx_sel() && !strb_cpu_n) || (fx_sel() && strb_cpu_n && !strb_ctl_n);
    cont  = strb_ctl_n && (strb_cpu_n || chip_en_n);
    if (start) begin m_base = addr; m_cnt = 2'd0; end
    else if (cont && !step_n) m_cnt = m_cnt + 2'd1;
    lo  = burst_xor ? (m_base[1:0] ^ m_cnt) : 2'((m_base[1:0] + m_cnt) % 4);
    eff = {m_base[AW-1:2], lo};
    if (fx_wcyc()) begin
      for (int k = 0; k < NL; k++) begin
        if (!wr_all_n || (!lane_gate_n && !lane_n[k])) begin
          mm[eff][k*LW +: LW] = wdata[k*LW +: LW];
          mk[eff][k] = 1'b1;
        end
      end
    end
    m_rd1 = (fx_sel() && !strb_cpu_n) || (fx_ctlside() && !fx_wreq());
    m_a1  = eff;
  endtask

  task automatic check_out(string tag);
    bit edrv;
    string t;
    bit bad;
    edrv = m_vld && !out_en_n && !sleep_i && !fx_wcyc();
    t = tag;
    if (t == "") begin
      if (sleep_i) t = "R11";
      else if (out_en_n) t = "R9";
      else if (fx_wcyc()) t = "R10";
      else t = "R8";
    end
    n_chk++;
    if (rdrive !== edrv) begin
      n_bad++;
      $display("FAIL %s rdrive actual=%0b expected=%0b t=%0t", t, rdrive, edrv, $time);
    end
    bad = 0;
    if (edrv) begin
      for (int k = 0; k < NL; k++)
        if (m_qk[k] && rdata[k*LW +: LW] !== m_q[k*LW +: LW]) bad = 1;
    end else if (rdata !== '0) bad = 1;
    if (bad) begin
      n_chk++; n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h known=%b t=%0t", t, rdata,
               edrv ? m_q : '0, m_qk, $time);
    end
  endtask

  task automatic cyc(string tag);
    #1 check_out(tag);
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    chip_en_n = 1; strb_ctl_n = 0; strb_cpu_n = 1; step_n = 1;
    wr_all_n = 1; lane_gate_n = 1; lane_n = '1; out_en_n = 0; sleep_i = 0;
    sel_a = 1; sel_b_n = 0;
  endtask

  task automatic go_cpu(logic [AW-1:0] a);
    chip_en_n = 0; sel_a = 1; sel_b_n = 0; strb_cpu_n = 0; strb_ctl_n = 1; addr = a;
  endtask
  task automatic go_ctl(logic [AW-1:0] a);
    chip_en_n = 0; sel_a = 1; sel_b_n = 0; strb_cpu_n = 1; strb_ctl_n = 0; addr = a;
  endtask
  task automatic go_cont(bit adv);
    chip_en_n = 1; strb_cpu_n = 1; strb_ctl_n = 1; step_n = !adv; addr = '0;
  endtask

  task automatic do_reset(bit order);
    rst_n = 0; burst_xor = order; idle();
    model_reset();
    repeat (2) @(negedge clk);
    #1 n_chk++;
    if (rdrive !== 1'b0 || rdata !== '0) begin
      n_bad++;
      $display("FAIL R1 reset rdrive=%0b rdata=%h expected 0/0", rdrive, rdata);
    end
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic burst_block(logic [AW-1:0] a, string tag);
    go_ctl(a); wr_all_n = 0; wdata = {4{9'(a) + 9'h101}}; cyc(tag);
    for (int i = 1; i < 4; i++) begin
      go_cont(1); wdata = {4{9'(a) + 9'h101 + 9'(i)}}; cyc(tag);
    end
    wr_all_n = 1;
    go_cpu({a[AW-1:2], 2'b00}); cyc(tag);
    for (int i = 1; i < 4; i++) begin go_cont(1); cyc(tag); end
    go_cont(0); cyc("R5"); cyc("R5");
    idle(); cyc(tag); cyc("R2"); cyc("R2");
  endtask

  task automatic rand_phase(int n);
    for (int i = 0; i < n; i++) begin
      chip_en_n   = ($urandom % 10) == 0;
      sel_a       = ($urandom % 12) != 0;
      sel_b_n     = ($urandom % 12) == 0;
      strb_cpu_n  = ($urandom % 7) != 0;
      strb_ctl_n  = ($urandom % 5) != 0;
      step_n      = $urandom % 2;
      wr_all_n    = ($urandom % 6) != 0;
      lane_gate_n = $urandom % 2;
      lane_n      = NL'($urandom);
      out_en_n    = ($urandom % 10) == 0;
      sleep_i     = ($urandom % 20) == 0;
      addr        = AW'($urandom);
      wdata       = {$urandom, $urandom};
      cyc("");
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_0107);
    for (int i = 0; i < DEP; i++) begin mm[i] = '0; mk[i] = '0; end
    @(negedge clk);

    do_reset(0);
    burst_block(6'd6, "R6");
    burst_block(6'd13, "R6");

    // R3: processor strobe ignored with chip enable high; never writes when selected
    idle(); chip_en_n = 1; strb_cpu_n = 0; strb_ctl_n = 1; step_n = 1; wr_all_n = 0;
    wdata = '1; cyc("R3");
    go_cpu(6'd13); wr_all_n = 0; lane_gate_n = 0; lane_n = '0; wdata = '0; cyc("R3");
    wr_all_n = 1; lane_gate_n = 1; lane_n = '1;
    go_cont(0); cyc("R3"); cyc("R3"); cyc("R3");

    // R4 / R7: controller start read vs lane writes, gate high ignores selects
    go_ctl(6'd20); wr_all_n = 1; lane_gate_n = 0; lane_n = 4'b1010; wdata = {4{9'h1a5}}; cyc("R7");
    lane_gate_n = 1; lane_n = 4'b0000; wdata = {4{9'h0ff}}; go_cont(0); cyc("R7");
    go_ctl(6'd20); cyc("R4"); go_cont(0); cyc("R4"); cyc("R4"); cyc("R4");
    go_ctl(6'd20); lane_gate_n = 0; lane_n = 4'b0101; wdata = {4{9'h033}}; cyc("R7");
    lane_gate_n = 1; lane_n = '1; go_cpu(6'd20); cyc("R7"); go_cont(0); cyc("R7"); cyc("R7");

    // R9 / R11 in the middle of a read burst
    go_cpu(6'd12); cyc("R8"); go_cont(1); cyc("R8");
    out_en_n = 1; cyc("R9"); out_en_n = 0; cyc("R9");
    sleep_i = 1; cyc("R11"); cyc("R11"); cyc("R11"); sleep_i = 0; cyc("R11"); cyc("R11");
    idle(); cyc("R2"); chip_en_n = 0; sel_a = 0; strb_ctl_n = 0; cyc("R2"); cyc("R2");
    rand_phase(4000);

    do_reset(1);
    for (int i = 0; i < DEP; i++) mk[i] = '0;
    burst_block(6'd33, "R6");
    burst_block(6'd46, "R6");
    rand_phase(4000);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired before completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule